// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns stereo sample pairs into a serial audio stream. A bit-period tick drives it. From that tick it produces a bit-clock pin, a data pin and a frame pin. Five framing formats can be selected at run time, and each format places the most significant bit at a different point relative to the frame edge. The bit-clock pin and the frame pin can each be inverted on their own.

Every channel occupies a 32-bit slot. The active sample width can be 16, 20, 24 or 32 bits, and each sample sits right-aligned in its 32-bit input word. A pair is taken in through a valid/ready handshake, but only at a frame boundary. If no pair is offered there, the block sends silence and flags an underrun. In the two DSP formats the left and right words can be moved to any 32-bit slot of a longer time-division frame.

The frame length, format, width and slot positions are captured at each frame boundary and hold for the whole frame. The inversion bits act at once.

Top module: `audtx_serializer`

## Requirements
- R1: While `rst` is high, and after it until the first launch: `sdata`=0, `underrun`=0, `in_ready`=0, `bclk_out` = NOT `inv_bclk`, `frame_out` = `inv_frame`.
- R2: With `fmt_sel`=0 (values 5 to 7 act the same), the frame level is low during launch indices 0 to 31 (left) and high during 32 to 63. Each word's MSB goes out one launch after the frame changes level.
- R3: With `fmt_sel`=1, the frame level is high during indices 0 to 31 (left) and low during 32 to 63. Each word's MSB goes out at the launch where the frame changes level.
- R4: With `fmt_sel`=2, the frame levels are the same as in R3. Each word's LSB goes out on the last index of its 32-bit half, its MSB goes out `width` launches before the next frame change, and the leading unused indices are 0.
- R5: With `fmt_sel`=3, the frame level is high only at index 0. The left MSB goes out at index 1 and the right word follows 32 indices later.
- R6: With `fmt_sel`=4, the frame level is high only at index 0. The left MSB goes out at index 0 and the right MSB at index 32.
- R7: A launch is a falling edge of `bclk_out` when `inv_bclk`=0 and a rising edge when `inv_bclk`=1. `sdata` and `frame_out` change only at launches. `frame_out` is the frame level XOR `inv_frame`.
- R8: `width_sel` 0/1/2/3 selects 16/20/24/32 bits, taken from bits [width-1:0] of each input word. Input bits above the width, and every index not carrying a sample bit, are sent as 0.
- R9: In DSP formats, a nonzero pair (`tdm_left`,`tdm_right`) gives a frame of SLOTS×32 launches with the left word in slot `tdm_left` and the right word in slot `tdm_right` (left wins if they are equal). (0,0), and any value in the other formats, gives a 64-launch frame with left in slot 0 and right in slot 1.
- R10: `in_ready` is high for exactly one clock, at the launch that starts a frame. The pair on `in_left`/`in_right` is accepted in that cycle if `in_valid` is high.
- R11: If `in_valid` is low at a frame start, that frame carries zero samples and `underrun` is high for the one clock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | Half-bit-period enable; two ticks make one bit period |
| fmt_sel | input | 3 | Framing format code |
| width_sel | input | 2 | Sample width code |
| inv_bclk | input | 1 | Invert the bit-clock pin |
| inv_frame | input | 1 | Invert the frame pin |
| tdm_left | input | $clog2(SLOTS) | Left word slot in DSP time-division frames |
| tdm_right | input | $clog2(SLOTS) | Right word slot in DSP time-division frames |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Frame start; pair taken this cycle |
| in_left | input | 32 | Left sample, right-aligned |
| in_right | input | 32 | Right sample, right-aligned |
| sdata | output | 1 | Serial data |
| bclk_out | output | 1 | Bit-clock pin |
| frame_out | output | 1 | Frame clock or one-bit sync pin |
| underrun | output | 1 | One-clock pulse when a frame starts without a pair |

## Verification
The embedded assertions check, on every cycle, several rules that hold for every format:
- launches are never back to back;
- data and frame pins change only on a launch;
- the ready pulse lasts a single clock;
- an underrun pulse follows only a frame start where no pair was offered;
- the bit index stays inside the captured frame length.

Where each bit lands needs the bench's scoreboard, which rebuilds the whole serial stream:
- the MSB position in each format;
- right-justified padding;
- time-division slot placement;
- pin inversion;
- the leftover bit that a delayed format carries across the frame start from the previous pair.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

    localparam int CHAN_BITS = 32;   // bit slots per channel word
    localparam int STEREO_LEN = 64;  // launches per frame without slot placement

    typedef enum logic [2:0] {
        FMT_I2S    = 3'd0,
        FMT_LEFTJ  = 3'd1,
        FMT_RIGHTJ = 3'd2,
        FMT_DSP_A  = 3'd3,
        FMT_DSP_B  = 3'd4
    } fmt_e;

    typedef struct packed {
        fmt_e       fmt;
        logic [1:0] wsel;
    } frame_cfg_t;

    function automatic fmt_e fmt_clean(input logic [2:0] code);
        return (code > 3'd4) ? FMT_I2S : fmt_e'(code);
    endfunction

    // MSB sent one launch after the frame reference
    function automatic logic fmt_delayed(input fmt_e f);
        return (f == FMT_I2S) || (f == FMT_DSP_A);
    endfunction

    function automatic logic fmt_dsp(input fmt_e f);
        return (f == FMT_DSP_A) || (f == FMT_DSP_B);
    endfunction

    function automatic int width_of(input logic [1:0] wsel);
        case (wsel)
            2'd0:    return 16;
            2'd1:    return 20;
            2'd2:    return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/audtx_clkgen.sv
module audtx_clkgen (
    input  logic clk,
    input  logic rst,
    input  logic bit_tick,
    input  logic inv_bclk,
    output logic launch,
    output logic bclk_pin
);
    logic phase_q;   // normal-polarity bit clock level

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= 1'b1;
        else if (bit_tick)
            phase_q <= ~phase_q;
    end

    // falling edge of the normal-polarity clock is the launch edge
    assign launch   = bit_tick & phase_q & ~rst;
    assign bclk_pin = phase_q ^ inv_bclk;

    // R7
    launch_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        launch |=> !launch);

endmodule

// File: rtl/audtx_framer.sv
module audtx_framer
    import audtx_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     launch,
    input  logic [2:0]               fmt_in,
    input  logic [1:0]               wsel_in,
    input  logic [$clog2(SLOTS)-1:0] lpos_in,
    input  logic [$clog2(SLOTS)-1:0] rpos_in,
    output logic                     boundary,
    output logic [$clog2(SLOTS)+4:0] bit_next,
    output frame_cfg_t               cfg_eff,
    output logic [$clog2(SLOTS)-1:0] lpos_eff,
    output logic [$clog2(SLOTS)-1:0] rpos_eff,
    output logic [$clog2(SLOTS)+5:0] flen_eff
);
    localparam int SPW  = $clog2(SLOTS);
    localparam int IDXW = SPW + 5;
    localparam int FLW  = IDXW + 1;
    localparam logic [FLW-1:0] LONG_LEN  = FLW'(SLOTS * CHAN_BITS);
    localparam logic [FLW-1:0] SHORT_LEN = FLW'(STEREO_LEN);

    logic              started_q;
    logic [IDXW-1:0]   bit_idx_q;
    frame_cfg_t        cfg_q;
    logic [SPW-1:0]    lpos_q, rpos_q;
    logic [FLW-1:0]    flen_q;
    logic              wrap;

    frame_cfg_t        cfg_in;
    logic              tdm_in;
    logic [SPW-1:0]    lpos_norm, rpos_norm;
    logic [FLW-1:0]    flen_in;

    always_comb begin
        cfg_in.fmt  = fmt_clean(fmt_in);
        cfg_in.wsel = wsel_in;
        tdm_in      = fmt_dsp(cfg_in.fmt) && ((lpos_in | rpos_in) != '0);
        lpos_norm   = tdm_in ? lpos_in : SPW'(0);
        rpos_norm   = tdm_in ? rpos_in : SPW'(1);
        flen_in     = tdm_in ? LONG_LEN : SHORT_LEN;
    end

    assign wrap     = !started_q || (FLW'(bit_idx_q) == flen_q - FLW'(1));
    assign boundary = launch & wrap;
    assign bit_next = wrap ? '0 : bit_idx_q + IDXW'(1);
    assign cfg_eff  = wrap ? cfg_in    : cfg_q;
    assign lpos_eff = wrap ? lpos_norm : lpos_q;
    assign rpos_eff = wrap ? rpos_norm : rpos_q;
    assign flen_eff = wrap ? flen_in   : flen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            started_q <= 1'b0;
            bit_idx_q <= '0;
            cfg_q     <= '{fmt: FMT_I2S, wsel: 2'd0};
            lpos_q    <= SPW'(0);
            rpos_q    <= SPW'(1);
            flen_q    <= SHORT_LEN;
        end else if (launch) begin
            started_q <= 1'b1;
            bit_idx_q <= bit_next;
            if (wrap) begin
                cfg_q  <= cfg_in;
                lpos_q <= lpos_norm;
                rpos_q <= rpos_norm;
                flen_q <= flen_in;
            end
        end
    end

    // R9
    bidx_range_chk: assert property (@(posedge clk) disable iff (rst)
        FLW'(bit_idx_q) < flen_q);

endmodule

// File: rtl/audtx_bitsel.sv
module audtx_bitsel
    import audtx_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  frame_cfg_t               cfg,
    input  logic [$clog2(SLOTS)-1:0] lpos,
    input  logic [$clog2(SLOTS)-1:0] rpos,
    input  logic [$clog2(SLOTS)+5:0] flen,
    input  logic [$clog2(SLOTS)+4:0] bit_next,
    input  logic [CHAN_BITS-1:0]     cur_left,
    input  logic [CHAN_BITS-1:0]     cur_right,
    input  logic [CHAN_BITS-1:0]     new_left,
    input  logic [CHAN_BITS-1:0]     new_right,
    output logic                     data_bit,
    output logic                     frame_lvl
);
    localparam int SPW  = $clog2(SLOTS);
    localparam int IDXW = SPW + 5;

    logic              dly;
    logic              at_start;
    logic [IDXW-1:0]   vpos;
    logic [SPW-1:0]    slot;
    logic [4:0]        pos;
    logic [CHAN_BITS-1:0] lw, rw, word;
    logic              hit;
    int                wid, off, q;

    always_comb begin
        dly      = fmt_delayed(cfg.fmt);
        at_start = (bit_next == '0);
        // delayed formats look one launch back, wrapping into the old frame
        if (dly)
            vpos = at_start ? IDXW'(flen - 1'b1) : bit_next - IDXW'(1);
        else
            vpos = bit_next;
        slot = vpos[IDXW-1:5];
        pos  = vpos[4:0];

        if (at_start && !dly) begin
            lw = new_left;
            rw = new_right;
        end else begin
            lw = cur_left;
            rw = cur_right;
        end

        hit  = 1'b1;
        word = '0;
        if (slot == lpos)      word = lw;
        else if (slot == rpos) word = rw;
        else                   hit  = 1'b0;

        wid = width_of(cfg.wsel);
        off = (cfg.fmt == FMT_RIGHTJ) ? (CHAN_BITS - wid) : 0;
        q   = int'(pos) - off;
        data_bit = (hit && q >= 0 && q < wid) ? word[wid - 1 - q] : 1'b0;

        case (cfg.fmt)
            FMT_LEFTJ, FMT_RIGHTJ: frame_lvl = (bit_next < IDXW'(CHAN_BITS));
            FMT_DSP_A, FMT_DSP_B:  frame_lvl = at_start;
            default:               frame_lvl = (bit_next >= IDXW'(CHAN_BITS));
        endcase
    end

endmodule

// File: rtl/audtx_serializer.sv
module audtx_serializer
    import audtx_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bit_tick,
    input  logic [2:0]               fmt_sel,
    input  logic [1:0]               width_sel,
    input  logic                     inv_bclk,
    input  logic                     inv_frame,
    input  logic [$clog2(SLOTS)-1:0] tdm_left,
    input  logic [$clog2(SLOTS)-1:0] tdm_right,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [31:0]              in_left,
    input  logic [31:0]              in_right,
    output logic                     sdata,
    output logic                     bclk_out,
    output logic                     frame_out,
    output logic                     underrun
);
    localparam int SPW  = $clog2(SLOTS);
    localparam int IDXW = SPW + 5;

    logic                 launch, boundary;
    logic [IDXW-1:0]      bit_next;
    frame_cfg_t           cfg_eff;
    logic [SPW-1:0]       lpos_eff, rpos_eff;
    logic [IDXW:0]        flen_eff;
    logic                 data_bit, frame_lvl;
    logic [CHAN_BITS-1:0] cur_l_q, cur_r_q, new_l, new_r;
    logic                 sd_q, fr_q, underrun_q;

    audtx_clkgen u_clk (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .inv_bclk(inv_bclk),
        .launch(launch), .bclk_pin(bclk_out)
    );

    audtx_framer #(.SLOTS(SLOTS)) u_frm (
        .clk(clk), .rst(rst), .launch(launch),
        .fmt_in(fmt_sel), .wsel_in(width_sel),
        .lpos_in(tdm_left), .rpos_in(tdm_right),
        .boundary(boundary), .bit_next(bit_next), .cfg_eff(cfg_eff),
        .lpos_eff(lpos_eff), .rpos_eff(rpos_eff), .flen_eff(flen_eff)
    );

    assign new_l = in_valid ? in_left  : '0;
    assign new_r = in_valid ? in_right : '0;

    audtx_bitsel #(.SLOTS(SLOTS)) u_sel (
        .cfg(cfg_eff), .lpos(lpos_eff), .rpos(rpos_eff), .flen(flen_eff),
        .bit_next(bit_next),
        .cur_left(cur_l_q), .cur_right(cur_r_q),
        .new_left(new_l), .new_right(new_r),
        .data_bit(data_bit), .frame_lvl(frame_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_l_q    <= '0;
            cur_r_q    <= '0;
            sd_q       <= 1'b0;
            fr_q       <= 1'b0;
            underrun_q <= 1'b0;
        end else begin
            underrun_q <= 1'b0;
            if (launch) begin
                sd_q <= data_bit;
                fr_q <= frame_lvl;
            end
            if (boundary) begin
                cur_l_q    <= new_l;
                cur_r_q    <= new_r;
                underrun_q <= !in_valid;
            end
        end
    end

    assign in_ready  = boundary;
    assign sdata     = sd_q;
    assign frame_out = fr_q ^ inv_frame;
    assign underrun  = underrun_q;

    // R10
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> !in_ready);

    // R11
    underrun_src_chk: assert property (@(posedge clk) disable iff (rst)
        underrun |-> $past(in_ready && !in_valid));

    // R7
    data_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sd_q) |-> $past(launch));

    // R7
    frame_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(fr_q) |-> $past(launch));

endmodule

// File: tb/tb_audtx_serializer.sv
module tb_audtx_serializer;
    localparam int SLOTS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_tick = 1'b0;
    logic [2:0]  fmt_sel = 3'd0;
    logic [1:0]  width_sel = 2'd0;
    logic        inv_bclk = 1'b0, inv_frame = 1'b0;
    logic [1:0]  tdm_left = 2'd0, tdm_right = 2'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_left = '0, in_right = '0;
    logic        sdata, bclk_out, frame_out, underrun;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_q[$];
    bit    mon_on = 0;
    logic  prev_b = 1'b1;
    string cur_tag = "";
    int    bit_no = 0;

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) bit_tick <= ~bit_tick;

    audtx_serializer #(.SLOTS(SLOTS)) dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .fmt_sel(fmt_sel),
        .width_sel(width_sel), .inv_bclk(inv_bclk), .inv_frame(inv_frame),
        .tdm_left(tdm_left), .tdm_right(tdm_right), .in_valid(in_valid),
        .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
        .sdata(sdata), .bclk_out(bclk_out), .frame_out(frame_out),
        .underrun(underrun)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // expected data bit at launch index b of a frame (R2-R6, R8, R9)
    function automatic logic xbit(int b, int flen, int fmt, int w, int lp, int rp,
                                  logic [31:0] cl, logic [31:0] cr,
                                  logic [31:0] pl, logic [31:0] pr);
        bit dly = (fmt == 0) || (fmt == 3) || (fmt > 4);
        int v, slot, p, q;
        logic [31:0] l, r;
        v = dly ? ((b == 0) ? flen - 1 : b - 1) : b;
        if (dly && b == 0) begin l = pl; r = pr; end
        else begin l = cl; r = cr; end
        slot = v / 32;
        p = v % 32;
        q = p - ((fmt == 2) ? 32 - w : 0);
        if (q < 0 || q >= w) return 1'b0;
        if (slot == lp) return l[w-1-q];
        if (slot == rp) return r[w-1-q];
        return 1'b0;
    endfunction

    function automatic logic xfr(int b, int fmt);
        if (fmt == 3 || fmt == 4) return b == 0;
        if (fmt == 1 || fmt == 2) return b < 32;
        return b >= 32;
    endfunction

    // monitor: pop one expected (data, frame) pair at every launch edge
    always @(negedge clk) begin
        if (mon_on && bclk_out != prev_b && bclk_out == inv_bclk) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s launch without expectation: actual %b%b expected none",
                         cur_tag, sdata, frame_out);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                if ({sdata, frame_out} !== e) begin
                    errors++;
                    $display("FAIL %s launch %0d data/frame: actual %b%b expected %b",
                             cur_tag, bit_no, sdata, frame_out, e);
                end
            end
            bit_no++;
        end
        prev_b = bclk_out;
    end

    task automatic run_scn(input string tag, input int fmt, input int wsel,
                           input bit ib, input bit ifr, input int tl, input int tr,
                           input int nfr, input int skip);
        int w, lp, rp, flen;
        bit tdm;
        logic [31:0] pl, pr, cl, cr;
        w    = (wsel == 0) ? 16 : (wsel == 1) ? 20 : (wsel == 2) ? 24 : 32;
        tdm  = (fmt == 3 || fmt == 4) && (tl != 0 || tr != 0);
        lp   = tdm ? tl : 0;
        rp   = tdm ? tr : 1;
        flen = tdm ? SLOTS * 32 : 64;

        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        fmt_sel = 3'(fmt); width_sel = 2'(wsel);
        inv_bclk = ib; inv_frame = ifr;
        tdm_left = 2'(tl); tdm_right = 2'(tr);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {31'd0, sdata}, 32'd0, "sdata in reset");
        check("R1", {31'd0, frame_out}, {31'd0, ifr}, "frame_out in reset");
        check("R1", {31'd0, bclk_out}, {31'd0, ~ib}, "bclk_out in reset");
        check("R1", {30'd0, in_ready, underrun}, 32'd0, "ready/underrun in reset");
        prev_b = bclk_out;
        cur_tag = tag; bit_no = 0; exp_q.delete();
        pl = '0; pr = '0;
        rst = 1'b0; mon_on = 1;
        for (int k = 0; k < nfr; k++) begin
            if (k == skip) begin
                cl = '0; cr = '0; in_valid = 1'b0;
            end else begin
                cl = 32'h9E37_79B9 ^ (32'h0101_0F0F * k) ^ {16'hF0F0, 16'(tag.len())};
                cr = 32'h6A09_E667 + (32'h1357_9BDF * k);
                in_left = cl; in_right = cr; in_valid = 1'b1;
            end
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            for (int b = 0; b < flen; b++)
                exp_q.push_back({xbit(b, flen, fmt, w, lp, rp, cl, cr, pl, pr),
                                 xfr(b, fmt) ^ ifr});
            @(negedge clk);
            in_valid = 1'b0;
            // R10 one-clock ready; R11 underrun only for a missing pair
            check("R10", {31'd0, in_ready}, 32'd0, "ready after frame start");
            check("R11", {31'd0, underrun}, {31'd0, (k == skip)}, "underrun pulse");
            pl = cl; pr = cr;
        end
        wait (exp_q.size() == 0);
        mon_on = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        run_scn("R2/R8",  0, 0, 0, 0, 0, 0, 3, -1);   // I2S, 16 bit
        run_scn("R3/R8",  1, 2, 0, 0, 0, 0, 3, -1);   // left-justified, 24 bit
        run_scn("R4/R8",  2, 1, 0, 0, 0, 0, 3, -1);   // right-justified, 20 bit
        run_scn("R4",     2, 0, 0, 0, 0, 0, 2, -1);   // right-justified, 16 bit
        run_scn("R5",     3, 3, 0, 0, 0, 0, 3, -1);   // DSP A, 32 bit
        run_scn("R6",     4, 0, 0, 0, 0, 0, 3, -1);   // DSP B, 16 bit
        run_scn("R7/R2",  0, 3, 1, 1, 0, 0, 3, -1);   // I2S both inverted, 32 bit
        run_scn("R7/R3",  1, 1, 1, 0, 0, 0, 2, -1);   // bit clock inverted only
        run_scn("R7/R6",  4, 2, 0, 1, 0, 0, 2, -1);   // frame inverted only
        run_scn("R9/R5",  3, 2, 0, 0, 2, 1, 3, -1);   // DSP A slots 2/1
        run_scn("R9/R6",  4, 3, 0, 0, 3, 0, 3, -1);   // DSP B slots 3/0
        run_scn("R9/R2",  0, 0, 0, 0, 2, 3, 2, -1);   // slot inputs ignored in I2S
        run_scn("R2",     6, 1, 0, 0, 0, 0, 2, -1);   // unused code acts as I2S
        run_scn("R11/R3", 1, 0, 0, 0, 0, 0, 4, 1);    // missing pair in frame 1
        run_scn("R11/R5", 3, 3, 0, 0, 0, 0, 3, 2);    // missing pair, delayed format
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule